// File: doc/BRIEF.md
# Performance Counter Enable Control

This block keeps the enable flags for a small performance monitor that has one cycle counter and four event counters. Software changes the flags through two register ports that share one bit layout. The clear port turns enables off wherever a written bit is 1. The set port turns enables on wherever a written bit is 1. Reading either register returns the flags that are currently stored.

Every access goes through a privilege check. A privileged access always completes. A user-mode access completes only when the user-access enable input is high. An access that is refused raises a fault flag for one cycle and changes no state. A global enable input gates all counter enables without disturbing the stored flags.

The block drives one registered effective count-enable per counter into the counters themselves.

Top module: `pmu_cnten_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all stored enables, `cnt_en`, `fault` and `rd_data` are 0.
- R2: On a granted clear write, every `clr_wdata` bit written as 1 clears the matching stored enable. Every bit written as 0 leaves its enable unchanged.
- R3: On a granted set write, every `set_wdata` bit written as 1 sets the matching stored enable. Every bit written as 0 leaves its enable unchanged.
- R4: Bit layout for both registers:
  - Word bit 31 maps to the cycle counter, which is `cnt_en` bit 4.
  - Word bits 3..0 map to event counters 3..0, which are `cnt_en` bits 3..0.
  - Writes to word bits 30..4 have no effect, and reads of those bits return 0.
- R5: A granted read returns the enable state in `rd_data` one cycle later. The value is the state before any write in the same cycle. When there is no granted read, `rd_data` is 0.
- R6: When `priv_mode` is 1, every read and write completes and no fault is raised.
- R7: When `priv_mode` is 0, accesses complete only if `user_en` is 1. Otherwise any read or write request makes `fault` high in the next cycle, changes no enable, and returns 0 in `rd_data`.
- R8: When a set write and a clear write hit the same bit in the same cycle, the clear wins and the enable ends at 0.
- R9: While `global_en` is 0, all `cnt_en` bits are 0. The stored enables are kept, stay readable, and drive `cnt_en` again once `global_en` returns to 1.
- R10: `cnt_en` is registered. It equals the post-write stored enables ANDed with `global_en` as sampled at the same clock edge, so it changes on the edge that applies the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request for the enable state |
| clr_wr_en | input | 1 | Write request to the clear register |
| clr_wdata | input | 32 | Clear register write data, ones clear |
| set_wr_en | input | 1 | Write request to the set register |
| set_wdata | input | 32 | Set register write data, ones set |
| priv_mode | input | 1 | 1 for privileged access, 0 for user mode |
| user_en | input | 1 | Allows user-mode access when 1 |
| global_en | input | 1 | Master enable for all counters |
| rd_data | output | 32 | Registered read data |
| fault | output | 1 | One-cycle undefined-instruction fault flag |
| cnt_en | output | 5 | Effective enables: bit 4 is the cycle counter, bits 3..0 are event counters |

## Verification
The bench writes the same bits through both ports in one cycle. A design that let the set win would leave the cycle counter running. It also writes only the reserved bits to the clear register. A design with an off-by-one field mapping would drop an event enable there or show reserved ones on read-back.

User-mode accesses made with the user enable low must raise a fault and leave the state untouched. A design that skipped the check would silently clear enables. A read in the same cycle as a write must return the old state. The bench also drops the global enable and then restores it. A design that wiped the stored flags on global disable would not recover the earlier `cnt_en` pattern.

// File: rtl/pmu_cnten_pkg.sv
package pmu_cnten_pkg;

    parameter int NUM_EVT = 4;
    parameter int DATA_W  = 32;

    localparam int EN_W    = NUM_EVT + 1;
    localparam int CYC_POS = DATA_W - 1;
    localparam int CYC_IDX = EN_W - 1;

    typedef logic [EN_W-1:0]   en_vec_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_GRANT = 2'd1,
        ACC_FAULT = 2'd2
    } acc_res_e;

    typedef struct packed {
        logic    rd;
        logic    clr;
        logic    set;
        en_vec_t clr_mask;
        en_vec_t set_mask;
    } acc_req_t;

    function automatic word_t en_to_word(input en_vec_t e);
        word_t w;
        w = '0;
        w[CYC_POS] = e[CYC_IDX];
        w[NUM_EVT-1:0] = e[NUM_EVT-1:0];
        return w;
    endfunction

endpackage

// File: rtl/pmu_acc_check.sv
module pmu_acc_check
    import pmu_cnten_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     any_req,
    input  logic     priv_mode,
    input  logic     user_en,
    output acc_res_e res,
    output logic     fault_q
);

    always_comb begin
        if (!any_req)
            res = ACC_IDLE;
        else if (priv_mode || user_en)
            res = ACC_GRANT;
        else
            res = ACC_FAULT;
    end

    always_ff @(posedge clk) begin
        if (rst)
            fault_q <= 1'b0;
        else
            fault_q <= (res == ACC_FAULT);
    end

endmodule

// File: rtl/pmu_en_store.sv
module pmu_en_store
    import pmu_cnten_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  acc_res_e res,
    input  acc_req_t req,
    output en_vec_t  en_q,
    output en_vec_t  en_next
);

    en_vec_t set_eff;
    en_vec_t clr_eff;

    always_comb begin
        set_eff = (res == ACC_GRANT && req.set) ? req.set_mask : '0;
        clr_eff = (res == ACC_GRANT && req.clr) ? req.clr_mask : '0;
        // clear applied after set so it wins on a shared bit
        en_next = (en_q | set_eff) & ~clr_eff;
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else
            en_q <= en_next;
    end

endmodule

// File: rtl/pmu_en_out.sv
module pmu_en_out
    import pmu_cnten_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  en_vec_t en_q,
    input  en_vec_t en_next,
    input  logic    global_en,
    input  logic    rd_grant,
    output en_vec_t cnt_en_q,
    output word_t   rd_data_q
);

    en_vec_t gate;

    generate
        for (genvar i = 0; i < EN_W; i++) begin : g_gate
            assign gate[i] = en_next[i] & global_en;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_en_q  <= '0;
            rd_data_q <= '0;
        end else begin
            cnt_en_q  <= gate;
            rd_data_q <= rd_grant ? en_to_word(en_q) : '0;
        end
    end

endmodule

// File: rtl/pmu_cnten_ctrl.sv
module pmu_cnten_ctrl
    import pmu_cnten_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              clr_wr_en,
    input  logic [DATA_W-1:0] clr_wdata,
    input  logic              set_wr_en,
    input  logic [DATA_W-1:0] set_wdata,
    input  logic              priv_mode,
    input  logic              user_en,
    input  logic              global_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              fault,
    output logic [EN_W-1:0]   cnt_en
);

    acc_req_t req;
    acc_res_e res;
    en_vec_t  en_q;
    en_vec_t  en_next;
    logic     unused_rsv;

    always_comb begin
        req.rd  = rd_en;
        req.clr = clr_wr_en;
        req.set = set_wr_en;
        req.clr_mask = {clr_wdata[CYC_POS], clr_wdata[NUM_EVT-1:0]};
        req.set_mask = {set_wdata[CYC_POS], set_wdata[NUM_EVT-1:0]};
    end

    assign unused_rsv = ^{clr_wdata[CYC_POS-1:NUM_EVT], set_wdata[CYC_POS-1:NUM_EVT]};

    pmu_acc_check u_acc (
        .clk       (clk),
        .rst       (rst),
        .any_req   (rd_en | clr_wr_en | set_wr_en),
        .priv_mode (priv_mode),
        .user_en   (user_en),
        .res       (res),
        .fault_q   (fault)
    );

    pmu_en_store u_store (
        .clk     (clk),
        .rst     (rst),
        .res     (res),
        .req     (req),
        .en_q    (en_q),
        .en_next (en_next)
    );

    pmu_en_out u_out (
        .clk       (clk),
        .rst       (rst),
        .en_q      (en_q),
        .en_next   (en_next),
        .global_en (global_en),
        .rd_grant  (req.rd && res == ACC_GRANT),
        .cnt_en_q  (cnt_en),
        .rd_data_q (rd_data)
    );

endmodule

// File: rtl/pmu_cnten_chk.sv
module pmu_cnten_chk
    import pmu_cnten_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              clr_wr_en,
    input logic [DATA_W-1:0] clr_wdata,
    input logic              set_wr_en,
    input logic              priv_mode,
    input logic              user_en,
    input logic              global_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              fault,
    input logic [EN_W-1:0]   cnt_en,
    input logic [EN_W-1:0]   en_q
);

    logic any_req;
    logic legal;

    assign any_req = rd_en | clr_wr_en | set_wr_en;
    assign legal   = priv_mode | user_en;

    AST_FAULT_ON_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (any_req && !legal) |=> fault); // R7
    AST_NO_FAULT_PRIV: assert property (@(posedge clk) disable iff (rst)
        (any_req && priv_mode) |=> !fault); // R6
    AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (any_req && !legal) |=> $stable(en_q)); // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (legal && clr_wr_en && clr_wdata[CYC_POS]) |=> !en_q[CYC_IDX]); // R8
    AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (rst)
        !global_en |=> (cnt_en == '0)); // R9
    AST_EFF_SUBSET: assert property (@(posedge clk) disable iff (rst)
        ((cnt_en & ~en_q) == '0)); // R10
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data[CYC_POS-1:NUM_EVT] == '0)); // R4
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0)); // R5

endmodule

bind pmu_cnten_ctrl pmu_cnten_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .clr_wr_en (clr_wr_en),
    .clr_wdata (clr_wdata),
    .set_wr_en (set_wr_en),
    .priv_mode (priv_mode),
    .user_en   (user_en),
    .global_en (global_en),
    .rd_data   (rd_data),
    .fault     (fault),
    .cnt_en    (cnt_en),
    .en_q      (en_q)
);

// File: tb/sim_pmu_cnten_ctrl.sv
module sim_pmu_cnten_ctrl;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 0, clr_wr_en = 0, set_wr_en = 0;
    logic [31:0] clr_wdata = '0, set_wdata = '0;
    logic        priv_mode = 1, user_en = 0, global_en = 1;
    logic [31:0] rd_data;
    logic        fault;
    logic [4:0]  cnt_en;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] rd;
        logic        flt;
        logic [4:0]  eff;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [4:0]  model = '0;

    always #(PERIOD/2) clk = ~clk;

    pmu_cnten_ctrl u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .clr_wr_en(clr_wr_en),
        .clr_wdata(clr_wdata), .set_wr_en(set_wr_en), .set_wdata(set_wdata),
        .priv_mode(priv_mode), .user_en(user_en), .global_en(global_en),
        .rd_data(rd_data), .fault(fault), .cnt_en(cnt_en)
    );

    function automatic logic [31:0] to_word(input logic [4:0] e);
        logic [31:0] w = '0;
        w[31] = e[4];
        w[3:0] = e[3:0];
        return w;
    endfunction

    function automatic logic [4:0] to_mask(input logic [31:0] w);
        return {w[31], w[3], w[2], w[1], w[0]};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic rd, input logic clr, input logic [31:0] cd,
                         input logic set, input logic [31:0] sd,
                         input logic priv, input logic uen, input logic glob,
                         input string tag);
        exp_t e;
        logic ok;
        @(negedge clk);
        rd_en = rd; clr_wr_en = clr; clr_wdata = cd;
        set_wr_en = set; set_wdata = sd;
        priv_mode = priv; user_en = uen; global_en = glob;
        ok = priv || uen;
        e.flt = (rd || clr || set) && !ok;
        e.rd = (rd && ok) ? to_word(model) : 32'h0;
        if (ok) begin
            if (set) model = model | to_mask(sd);
            if (clr) model = model & ~to_mask(cd);
        end
        e.eff = glob ? model : 5'h0;
        e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "rd_data", rd_data, e.rd);
            check(e.tag, "fault", {31'h0, fault}, {31'h0, e.flt});
            check(e.tag, "cnt_en", {27'h0, cnt_en}, {27'h0, e.eff});
        end
    end

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet during reset
        check("R1", "rst rd_data", rd_data, 32'h0);
        check("R1", "rst fault", {31'h0, fault}, 32'h0);
        check("R1", "rst cnt_en", {27'h0, cnt_en}, 32'h0);
        rst = 1'b0;
        drive(0, 0, 0, 0, 0, 1, 0, 1, "R1");
        drive(1, 0, 0, 0, 0, 1, 0, 1, "R1");
        // R3 R6: privileged set of every bit
        drive(0, 0, 0, 1, 32'hFFFF_FFFF, 1, 0, 1, "R3");
        // R4 R5: read back, reserved bits zero
        drive(1, 0, 0, 0, 0, 1, 0, 1, "R4");
        // R2: clear event 2 and 0 only
        drive(0, 1, 32'h0000_0005, 0, 0, 1, 0, 1, "R2");
        drive(1, 0, 0, 0, 0, 1, 0, 1, "R2");
        // R4: reserved-only clear has no effect
        drive(0, 1, 32'h7FFF_FFF0, 0, 0, 1, 0, 1, "R4");
        drive(1, 0, 0, 0, 0, 1, 0, 1, "R4");
        // R8: set and clear on same bits, clear wins
        drive(0, 1, 32'h8000_0001, 1, 32'h8000_0005, 1, 0, 1, "R8");
        drive(1, 0, 0, 0, 0, 1, 0, 1, "R8");
        // R7: user access refused, no state change
        drive(0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, "R7");
        drive(1, 0, 0, 0, 0, 0, 0, 1, "R7");
        drive(0, 0, 0, 1, 32'h0000_0002, 0, 0, 1, "R7");
        drive(1, 0, 0, 0, 0, 1, 0, 1, "R7");
        // R7: user access allowed
        drive(0, 1, 32'h0000_0008, 0, 0, 0, 1, 1, "R7");
        drive(1, 0, 0, 0, 0, 0, 1, 1, "R7");
        // R9: global disable masks, state kept
        drive(0, 1, 32'h0000_0000, 1, 32'h8000_0003, 1, 0, 0, "R9");
        drive(1, 0, 0, 0, 0, 1, 0, 0, "R9");
        drive(0, 0, 0, 0, 0, 1, 0, 1, "R9");
        // R10 R5: read with write same cycle returns pre-write state
        drive(1, 1, 32'h0000_0002, 0, 0, 1, 0, 1, "R10");
        drive(1, 0, 0, 1, 32'h0000_0004, 1, 0, 1, "R5");
        drive(0, 0, 0, 0, 0, 1, 0, 1, "R10");
        drive(0, 0, 0, 0, 0, 1, 0, 1, "R6");
        repeat (3) @(posedge clk);
        #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule